// File: doc/BRIEF.md
# Per-Source Row Batch Former

This block sits at the front of a staged memory scheduler. Several independent requesters (processor cores, a graphics engine, DMA engines) each push memory requests into their own lane. Every lane is a plain in-order FIFO. Consecutive requests from one lane that address the same DRAM bank and row are grouped into a batch. The batch stays open until something ends it. Once it is closed, it is offered to the downstream batch scheduler as one unit.

A batch ends for one of three reasons. The lane receives a request for a different bank/row pair. The batch has been open for the programmed number of cycles. Or the request just accepted fills the lane. The lane then tags the final entry of the batch as last-of-batch. Lanes never share storage and never mix batches.

The downstream scheduler sees a ready flag per lane and the head entry of each lane. It removes entries one at a time with a per-lane pop strobe. The last-of-batch tag on the head tells the scheduler where the current batch stops.

Top module: `row_batch_former`

## Requirements
- R1: Each lane delivers its requests at its head in arrival order, with bank, row and tag fields unchanged. Lanes do not affect one another.
- R2: A request whose bank and row both equal those of the lane's open batch joins that batch. Every entry except the final one of a batch carries a last flag of 0.
- R3: An accepted request with a different bank/row pair closes the open batch. The previous entry's last flag becomes 1, and the ready flag is high after that clock edge. The new request opens a new batch.
- R4: A request with the same row number in a different bank counts as a different pair and closes the open batch.
- R5: An open batch closes at the edge that comes `cfg_window` cycles after the edge that enqueued its first entry. A request accepted at that same edge opens a new batch. Window values 0 and 1 both give batches of one entry.
- R6: `in_ready` of a lane is low exactly when the lane holds DEPTH entries. The request that fills the lane is stored with last flag 1 and closes its batch.
- R7: `batch_ready` of a lane is high exactly when the lane holds at least one entry of a closed batch. `out_last` is the last flag of the head entry and is 0 when the lane is empty.
- R8: A pop strobe while the lane's `batch_ready` is low has no effect. Entries of an open batch are never removed.
- R9: After reset every lane is empty, `in_ready` is all ones and `batch_ready` is all zeros.
- R10: A pop and an accepted push on the same lane in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_window | input | TMR_W | Batch age limit in cycles |
| in_valid | input | NUM_SRC | Per-lane request strobe |
| in_ready | output | NUM_SRC | Per-lane space available |
| in_bank | input | NUM_SRC*BANK_W | Per-lane request bank, lane s at bits s*BANK_W |
| in_row | input | NUM_SRC*ROW_W | Per-lane request row |
| in_tag | input | NUM_SRC*TAG_W | Per-lane request payload tag |
| batch_ready | output | NUM_SRC | Lane holds a closed batch |
| deq_pop | input | NUM_SRC | Per-lane remove-head strobe |
| out_bank | output | NUM_SRC*BANK_W | Head entry bank per lane |
| out_row | output | NUM_SRC*ROW_W | Head entry row per lane |
| out_tag | output | NUM_SRC*TAG_W | Head entry tag per lane |
| out_last | output | NUM_SRC | Head entry is last of its batch |

## Verification
The hardest cases to reach are the ones where two closing causes land on the same edge. One is a different-row request that also fills the lane, which closes two batches at once. Another is a request that arrives exactly at the edge where the window runs out. A third is a pop of a batch's final entry at the edge where the open batch closes. Directed sequences set up a full lane and an exact window expiry. A long random phase then uses two banks and three rows and keeps changing the window between 0, 1, 3 and 8. This keeps the lanes near full and makes these coincidences frequent. A behavioural queue model is compared against every lane on every cycle.

// File: rtl/rbf_pkg.sv
package rbf_pkg;

   typedef enum logic {
      LANE_IDLE = 1'b0,
      LANE_OPEN = 1'b1
   } lane_state_e;

endpackage

// File: rtl/rbf_fifo.sv
module rbf_fifo #(
   parameter int DEPTH  = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] push_data,
   input  logic              push_last,
   input  logic              pop,
   input  logic              mark_prev,
   output logic [$clog2(DEPTH+1)-1:0] count,
   output logic [DATA_W-1:0] head_data,
   output logic              head_last
);
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH+1);
   localparam logic [PTR_W-1:0] TOP_IDX = PTR_W'(DEPTH-1);

   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [DEPTH-1:0]  last_q;
   logic [PTR_W-1:0]  wr_ptr, rd_ptr, prev_ptr;
   logic [CNT_W-1:0]  cnt_q;

   assign prev_ptr  = (wr_ptr == '0) ? TOP_IDX : wr_ptr - 1'b1;
   assign count     = cnt_q;
   assign head_data = mem_q[rd_ptr];
   assign head_last = last_q[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) mem_q[wr_ptr] <= push_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q <= '0;
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (mark_prev) last_q[prev_ptr] <= 1'b1;
         if (push) begin
            last_q[wr_ptr] <= push_last;
            wr_ptr <= (wr_ptr == TOP_IDX) ? '0 : wr_ptr + 1'b1;
         end
         if (pop) rd_ptr <= (rd_ptr == TOP_IDX) ? '0 : rd_ptr + 1'b1;
         cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
      end
   end
endmodule

// File: rtl/rbf_batch_ctl.sv
module rbf_batch_ctl
   import rbf_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int KEY_W = 6,
   parameter int TMR_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TMR_W-1:0] cfg_window,
   input  logic             push,
   input  logic [KEY_W-1:0] key_in,
   input  logic             fill_now,
   input  logic             pop_last,
   output logic             mark_prev,
   output logic             has_closed
);
   localparam int CNT_W = $clog2(DEPTH+1);

   lane_state_e      st_q;
   logic [KEY_W-1:0] key_q;
   logic [TMR_W-1:0] age_q, age_inc;
   logic [CNT_W-1:0] closed_q;
   logic             is_open, expire, diff_key, close_old, open_new, fill_close;

   assign is_open    = (st_q == LANE_OPEN);
   assign expire     = is_open && (age_q >= cfg_window);
   assign diff_key   = is_open && push && (key_in != key_q);
   assign close_old  = expire || diff_key;
   assign open_new   = push && (!is_open || close_old);
   assign fill_close = push && fill_now;
   assign mark_prev  = close_old;
   assign has_closed = (closed_q != '0);
   assign age_inc    = (&age_q) ? age_q : age_q + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q     <= LANE_IDLE;
         key_q    <= '0;
         age_q    <= '0;
         closed_q <= '0;
      end else begin
         closed_q <= closed_q + CNT_W'(close_old) + CNT_W'(fill_close)
                     - CNT_W'(pop_last);
         if (open_new) begin
            key_q <= key_in;
            age_q <= TMR_W'(1);
            st_q  <= fill_now ? LANE_IDLE : LANE_OPEN;
         end else if (push) begin
            age_q <= age_inc;
            if (fill_now) st_q <= LANE_IDLE;
         end else if (close_old) begin
            st_q <= LANE_IDLE;
         end else if (is_open) begin
            age_q <= age_inc;
         end
      end
   end
endmodule

// File: rtl/rbf_lane.sv
module rbf_lane #(
   parameter int DEPTH  = 4,
   parameter int BANK_W = 2,
   parameter int ROW_W  = 4,
   parameter int TAG_W  = 4,
   parameter int TMR_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TMR_W-1:0]  cfg_window,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [BANK_W-1:0] req_bank,
   input  logic [ROW_W-1:0]  req_row,
   input  logic [TAG_W-1:0]  req_tag,
   output logic              ready,
   input  logic              pop_req,
   output logic [BANK_W-1:0] hd_bank,
   output logic [ROW_W-1:0]  hd_row,
   output logic [TAG_W-1:0]  hd_tag,
   output logic              hd_last
);
   localparam int KEY_W  = BANK_W + ROW_W;
   localparam int DATA_W = KEY_W + TAG_W;
   localparam int CNT_W  = $clog2(DEPTH+1);

   logic [CNT_W-1:0]  cnt, cnt_next;
   logic [DATA_W-1:0] hd_data;
   logic              push_ok, pop_ok, fill_now, mark_prev, has_closed, raw_last;

   assign req_ready = (cnt != CNT_W'(DEPTH));
   assign push_ok   = req_valid && req_ready;
   assign pop_ok    = pop_req && has_closed;
   assign cnt_next  = cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);
   assign fill_now  = (cnt_next == CNT_W'(DEPTH));
   assign ready     = has_closed;

   rbf_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push_ok),
      .push_data ({req_bank, req_row, req_tag}),
      .push_last (fill_now),
      .pop       (pop_ok),
      .mark_prev (mark_prev),
      .count     (cnt),
      .head_data (hd_data),
      .head_last (raw_last)
   );

   rbf_batch_ctl #(.DEPTH(DEPTH), .KEY_W(KEY_W), .TMR_W(TMR_W)) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_window (cfg_window),
      .push       (push_ok),
      .key_in     ({req_bank, req_row}),
      .fill_now   (fill_now),
      .pop_last   (pop_ok && raw_last),
      .mark_prev  (mark_prev),
      .has_closed (has_closed)
   );

   assign {hd_bank, hd_row, hd_tag} = hd_data;
   assign hd_last = raw_last && (cnt != '0);
endmodule

// File: rtl/row_batch_former.sv
module row_batch_former #(
   parameter int NUM_SRC = 3,
   parameter int DEPTH   = 4,
   parameter int BANK_W  = 2,
   parameter int ROW_W   = 4,
   parameter int TAG_W   = 4,
   parameter int TMR_W   = 6
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [TMR_W-1:0]          cfg_window,
   input  logic [NUM_SRC-1:0]        in_valid,
   output logic [NUM_SRC-1:0]        in_ready,
   input  logic [NUM_SRC*BANK_W-1:0] in_bank,
   input  logic [NUM_SRC*ROW_W-1:0]  in_row,
   input  logic [NUM_SRC*TAG_W-1:0]  in_tag,
   output logic [NUM_SRC-1:0]        batch_ready,
   input  logic [NUM_SRC-1:0]        deq_pop,
   output logic [NUM_SRC*BANK_W-1:0] out_bank,
   output logic [NUM_SRC*ROW_W-1:0]  out_row,
   output logic [NUM_SRC*TAG_W-1:0]  out_tag,
   output logic [NUM_SRC-1:0]        out_last
);
   initial begin
      assert (NUM_SRC >= 1) else $error("NUM_SRC must be at least 1");
      assert (DEPTH >= 2)   else $error("DEPTH must be at least 2");
      assert (BANK_W >= 1 && ROW_W >= 1 && TAG_W >= 1) else $error("field widths must be positive");
      assert (TMR_W >= 2)   else $error("TMR_W must be at least 2");
   end

   for (genvar s = 0; s < NUM_SRC; s++) begin : g_lane
      rbf_lane #(
         .DEPTH(DEPTH), .BANK_W(BANK_W), .ROW_W(ROW_W),
         .TAG_W(TAG_W), .TMR_W(TMR_W)
      ) u_lane (
         .clk        (clk),
         .rst_n      (rst_n),
         .cfg_window (cfg_window),
         .req_valid  (in_valid[s]),
         .req_ready  (in_ready[s]),
         .req_bank   (in_bank[s*BANK_W +: BANK_W]),
         .req_row    (in_row[s*ROW_W +: ROW_W]),
         .req_tag    (in_tag[s*TAG_W +: TAG_W]),
         .ready      (batch_ready[s]),
         .pop_req    (deq_pop[s]),
         .hd_bank    (out_bank[s*BANK_W +: BANK_W]),
         .hd_row     (out_row[s*ROW_W +: ROW_W]),
         .hd_tag     (out_tag[s*TAG_W +: TAG_W]),
         .hd_last    (out_last[s])
      );
   end
endmodule

// File: rtl/rbf_chk.sv
module rbf_chk #(
   parameter int NUM_SRC = 3,
   parameter int BANK_W  = 2,
   parameter int ROW_W   = 4,
   parameter int TAG_W   = 4
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic [NUM_SRC-1:0]        in_ready,
   input logic [NUM_SRC-1:0]        batch_ready,
   input logic [NUM_SRC-1:0]        deq_pop,
   input logic [NUM_SRC*BANK_W-1:0] out_bank,
   input logic [NUM_SRC*ROW_W-1:0]  out_row,
   input logic [NUM_SRC*TAG_W-1:0]  out_tag,
   input logic [NUM_SRC-1:0]        out_last
);
   for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
      // R7
      last_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
         out_last[s] |-> batch_ready[s]);
      // R6
      full_forces_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !in_ready[s] |-> batch_ready[s]);
      // R8
      ready_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (batch_ready[s] && !deq_pop[s]) |=> batch_ready[s]);
      // R1
      head_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (batch_ready[s] && !deq_pop[s]) |=>
            ($stable(out_bank[s*BANK_W +: BANK_W]) && $stable(out_row[s*ROW_W +: ROW_W])
             && $stable(out_tag[s*TAG_W +: TAG_W]) && $stable(out_last[s])));
   end
endmodule

bind row_batch_former rbf_chk #(
   .NUM_SRC(NUM_SRC), .BANK_W(BANK_W), .ROW_W(ROW_W), .TAG_W(TAG_W)
) u_rbf_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_ready    (in_ready),
   .batch_ready (batch_ready),
   .deq_pop     (deq_pop),
   .out_bank    (out_bank),
   .out_row     (out_row),
   .out_tag     (out_tag),
   .out_last    (out_last)
);

// File: tb/test_row_batch_former.sv
`timescale 1ns/1ps
module test_row_batch_former;
   localparam int NS = 3, DEPTH = 4, BW = 2, RW = 4, TW = 4, TMW = 6;

   logic clk = 1'b0, rst_n = 1'b0;
   logic [TMW-1:0]   cfg_window = 6'd5;
   logic [NS-1:0]    in_valid = '0, deq_pop = '0;
   logic [NS*BW-1:0] in_bank = '0;
   logic [NS*RW-1:0] in_row = '0;
   logic [NS*TW-1:0] in_tag = '0;
   logic [NS-1:0]    in_ready, batch_ready, out_last;
   logic [NS*BW-1:0] out_bank;
   logic [NS*RW-1:0] out_row;
   logic [NS*TW-1:0] out_tag;

   always #2.5 clk = ~clk;

   row_batch_former #(.NUM_SRC(NS), .DEPTH(DEPTH), .BANK_W(BW), .ROW_W(RW),
                      .TAG_W(TW), .TMR_W(TMW)) i_row_batch_former (
      .clk(clk), .rst_n(rst_n), .cfg_window(cfg_window),
      .in_valid(in_valid), .in_ready(in_ready), .in_bank(in_bank), .in_row(in_row),
      .in_tag(in_tag), .batch_ready(batch_ready), .deq_pop(deq_pop),
      .out_bank(out_bank), .out_row(out_row), .out_tag(out_tag), .out_last(out_last));

   typedef struct packed {
      logic [BW-1:0] b;
      logic [RW-1:0] r;
      logic [TW-1:0] t;
      logic          l;
   } ent_t;

   ent_t mq [NS][$];
   bit   mopen [NS];
   logic [BW+RW-1:0] mkey [NS];
   int   mage [NS];
   int   mncl [NS];
   int   errors = 0, checks = 0;
   bit   run_cmp = 0, done = 0;

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference model
   always @(posedge clk) begin
      ent_t e;
      bit pu, po, ex, df, co, fa, was_open;
      logic [BW+RW-1:0] nk;
      if (!rst_n) begin
         for (int s = 0; s < NS; s++) begin
            mq[s].delete(); mopen[s] = 0; mage[s] = 0; mncl[s] = 0; mkey[s] = '0;
         end
      end else begin
         for (int s = 0; s < NS; s++) begin
            nk = {in_bank[s*BW +: BW], in_row[s*RW +: RW]};
            pu = in_valid[s] && (mq[s].size() < DEPTH);
            po = deq_pop[s] && (mncl[s] > 0);
            was_open = mopen[s];
            ex = was_open && (mage[s] >= int'(cfg_window));
            df = was_open && pu && (nk != mkey[s]);
            co = ex || df;
            if (co) begin
               e = mq[s][mq[s].size()-1]; e.l = 1'b1;
               mq[s][mq[s].size()-1] = e;
               mncl[s]++;
            end
            if (po) begin
               e = mq[s].pop_front();
               if (e.l) mncl[s]--;
            end
            fa = pu && (mq[s].size() + 1 == DEPTH);
            if (pu) begin
               e.b = in_bank[s*BW +: BW]; e.r = in_row[s*RW +: RW];
               e.t = in_tag[s*TW +: TW];  e.l = fa;
               mq[s].push_back(e);
               if (fa) mncl[s]++;
            end
            if (pu && (!was_open || co)) begin
               mopen[s] = !fa; mage[s] = 1; mkey[s] = nk;
            end else if (pu) begin
               if (fa) mopen[s] = 0;
               else if (mage[s] < 63) mage[s]++;
            end else if (co) begin
               mopen[s] = 0;
            end else if (was_open && mage[s] < 63) begin
               mage[s]++;
            end
         end
      end
   end

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (run_cmp) begin
         for (int s = 0; s < NS; s++) begin
            chk("R6 in_ready", int'(in_ready[s]), int'(mq[s].size() < DEPTH));
            chk("R7 batch_ready", int'(batch_ready[s]), int'(mncl[s] > 0));
            if (mq[s].size() > 0) begin
               chk("R1 head bank", int'(out_bank[s*BW +: BW]), int'(mq[s][0].b));
               chk("R1 head row",  int'(out_row[s*RW +: RW]),  int'(mq[s][0].r));
               chk("R1 head tag",  int'(out_tag[s*TW +: TW]),  int'(mq[s][0].t));
               chk("R2 head last", int'(out_last[s]), int'(mq[s][0].l));
            end else begin
               chk("R7 empty last", int'(out_last[s]), 0);
            end
         end
      end
   end

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic push1(int s, int b, int r, int t);
      in_valid[s] = 1'b1;
      in_bank[s*BW +: BW] = BW'(b);
      in_row[s*RW +: RW]  = RW'(r);
      in_tag[s*TW +: TW]  = TW'(t);
      cyc();
      in_valid[s] = 1'b0;
   endtask

   task automatic drain(int s);
      for (int k = 0; k < 16 && batch_ready[s]; k++) begin
         deq_pop[s] = 1'b1;
         cyc();
         deq_pop[s] = 1'b0;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (4) cyc();
      rst_n = 1'b1;
      cyc();
      run_cmp = 1;
      chk("R9 in_ready", int'(in_ready), (1 << NS) - 1);
      chk("R9 batch_ready", int'(batch_ready), 0);

      // R2 / R3 on lane 0
      push1(0, 0, 1, 1);
      push1(0, 0, 1, 2);
      chk("R2 same row stays open", int'(batch_ready[0]), 0);
      push1(0, 0, 2, 3);
      chk("R3 row change closes", int'(batch_ready[0]), 1);
      drain(0);

      // R8 and R5 on lane 2 (window 5)
      push1(2, 1, 5, 9);
      deq_pop[2] = 1'b1;
      cyc();
      deq_pop[2] = 1'b0;
      chk("R8 pop ignored tag", int'(out_tag[2*TW +: TW]), 9);
      chk("R8 pop ignored ready", int'(batch_ready[2]), 0);
      repeat (3) cyc();
      chk("R5 before window", int'(batch_ready[2]), 0);
      cyc();
      chk("R5 at window", int'(batch_ready[2]), 1);
      chk("R5 last tag", int'(out_last[2]), 1);
      drain(2);

      // R4 and R6 on lane 1
      cfg_window = 6'd40;
      push1(1, 0, 3, 4);
      push1(1, 1, 3, 5);
      chk("R4 bank change closes", int'(batch_ready[1]), 1);
      chk("R4 head last", int'(out_last[1]), 1);
      drain(1);
      push1(1, 1, 3, 6);
      push1(1, 1, 3, 7);
      push1(1, 1, 3, 8);
      chk("R6 full backpressure", int'(in_ready[1]), 0);
      chk("R6 full closes", int'(batch_ready[1]), 1);

      // R10 simultaneous pop and push
      deq_pop[1] = 1'b1;
      cyc();
      in_valid[1] = 1'b1;
      in_bank[1*BW +: BW] = 2'd0;
      in_row[1*RW +: RW]  = 4'd7;
      in_tag[1*TW +: TW]  = 4'd10;
      cyc();
      in_valid[1] = 1'b0;
      deq_pop[1]  = 1'b0;
      chk("R10 push+pop keeps space", int'(in_ready[1]), 1);
      chk("R10 head advanced", int'(out_tag[1*TW +: TW]), 7);

      // random phase
      for (int c = 0; c < 4000; c++) begin
         if (c % 400 == 0) begin
            case ($urandom_range(0, 3))
               0: cfg_window = 6'd0;
               1: cfg_window = 6'd1;
               2: cfg_window = 6'd3;
               default: cfg_window = 6'd8;
            endcase
         end
         for (int s = 0; s < NS; s++) begin
            in_valid[s] = ($urandom_range(0, 99) < 60);
            in_bank[s*BW +: BW] = BW'($urandom_range(0, 1));
            in_row[s*RW +: RW]  = RW'($urandom_range(0, 2));
            in_tag[s*TW +: TW]  = TW'($urandom_range(0, 15));
            deq_pop[s] = ($urandom_range(0, 99) < 45);
         end
         cyc();
      end
      in_valid = '0;
      deq_pop  = '0;
      repeat (3) cyc();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule